// File: doc/BRIEF.md
# Level-Driven Interrupt Aggregator

This block gathers up to 32 level-sensitive interrupt sources into one interrupt line for the parent processor. Each source owns one bit in two state words: a "live" word and a "blocked" word. When a source line changes level, the new level is copied into that source's bits. A rising line sets its live bit and clears its blocked bit. A falling line does the reverse. Software can also overwrite either word at any time. After every update, any live bit whose blocked bit is set is forced to zero.

Register access uses a simple single-cycle bus with an 8-bit byte offset. The bus carries valid, write, address, write data and registered read data. A fourth word, the class word, is only stored and read back. A status alias returns the live word. The parent interrupt is a registered OR of the live word.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the class, live and blocked words read zero, the interrupt output is low and read data is zero.
- R2: In the cycle after a source line changes from low to high, its live bit is 1 and its blocked bit is 0.
- R3: In the cycle after a source line changes from high to low, its live bit is 0 and its blocked bit is 1.
- R4: After any update, a live bit whose blocked bit is 1 reads 0. This applies to a software write to the live word at offset 0x80 and to a write to the blocked word at offset 0x78.
- R5: The interrupt output equals the OR of all live bits as they stood one clock earlier.
- R6: Offsets are as follows. 0x6C is the class word (read/write). 0x78 is the blocked word (read/write). 0x80 is the live word (read/write). 0x9C is status (read-only) and returns the live word.
- R7: A read of any other offset returns 0. A write to any other offset, or to 0x9C, changes no state.
- R8: The class word has no effect on the live word or on the interrupt output.
- R9: When a software write and a source level change hit the same bit in the same cycle, the source update wins for that bit. The masking rule of R4 is then applied to the result.
- R10: Read data appears on the cycle after a read request and is 0 in every cycle that follows no read request.
- R11: A source that holds a steady level does not re-apply its level. A live bit cleared by software stays cleared while its source remains high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src | input | NSRC | Level-sensitive interrupt source lines |
| bus_valid | input | 1 | Bus request strobe |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Registered read data |
| irq | output | 1 | Registered parent interrupt |

## Verification
The bench builds the block with its default of 32 sources. At this width every offset and bit position in the requirements is exactly what software sees. All-ones writes therefore reach the top bit and the full-word masking of the blocked word. This also exposes collisions of a write and a source change on chosen bits, so the priority between them can be observed through the ordinary read port.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] OFF_CLASS   = 8'h6C;
  localparam logic [ADDR_W-1:0] OFF_BLOCKED = 8'h78;
  localparam logic [ADDR_W-1:0] OFF_LIVE    = 8'h80;
  localparam logic [ADDR_W-1:0] OFF_STATUS  = 8'h9C;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_CLASS,
    SEL_BLOCKED,
    SEL_LIVE,
    SEL_STATUS
  } reg_sel_e;

  function automatic reg_sel_e decode_offset(input logic [ADDR_W-1:0] off);
    case (off)
      OFF_CLASS:   return SEL_CLASS;
      OFF_BLOCKED: return SEL_BLOCKED;
      OFF_LIVE:    return SEL_LIVE;
      OFF_STATUS:  return SEL_STATUS;
      default:     return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/irq_agg_srcdet.sv
module irq_agg_srcdet #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  output logic [NSRC-1:0] chg,
  output logic [NSRC-1:0] lvl
);
  logic [NSRC-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= src;
  end

  assign chg = src ^ prev_q;
  assign lvl = src;
endmodule

// File: rtl/irq_agg_regfile.sv
module irq_agg_regfile
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_stb,
  input  reg_sel_e        sel,
  input  logic [NSRC-1:0] wdata,
  input  logic [NSRC-1:0] chg,
  input  logic [NSRC-1:0] lvl,
  output logic [NSRC-1:0] class_q,
  output logic [NSRC-1:0] live_q,
  output logic [NSRC-1:0] blocked_q
);
  // one bit of state after software write, then source update
  function automatic logic merge_bit(input logic old_v, input logic sw_we, input logic sw_v,
                                     input logic ch, input logic src_v);
    logic v;
    v = sw_we ? sw_v : old_v;
    return ch ? src_v : v;
  endfunction

  logic wr_live, wr_blocked, wr_class;
  logic [NSRC-1:0] live_pre, blocked_n, live_n;

  assign wr_live    = wr_stb && (sel == SEL_LIVE);
  assign wr_blocked = wr_stb && (sel == SEL_BLOCKED);
  assign wr_class   = wr_stb && (sel == SEL_CLASS);

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    assign live_pre[i]  = merge_bit(live_q[i], wr_live, wdata[i], chg[i], lvl[i]);
    assign blocked_n[i] = merge_bit(blocked_q[i], wr_blocked, wdata[i], chg[i], ~lvl[i]);
    assign live_n[i]    = live_pre[i] & ~blocked_n[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      class_q   <= '0;
      live_q    <= '0;
      blocked_q <= '0;
    end else begin
      if (wr_class) class_q <= wdata;
      live_q    <= live_n;
      blocked_q <= blocked_n;
    end
  end

  // R4
  no_masked_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (live_q & blocked_q) == '0);

  // R2
  rise_sets_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((live_q & $past(chg & lvl)) == $past(chg & lvl)) &&
             ((blocked_q & $past(chg & lvl)) == '0));

  // R3
  fall_sets_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((blocked_q & $past(chg & ~lvl)) == $past(chg & ~lvl)) &&
             ((live_q & $past(chg & ~lvl)) == '0));

  // R7
  class_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_class |=> $stable(class_q));
endmodule

// File: rtl/irq_agg_rdport.sv
module irq_agg_rdport
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            rd_stb,
  input  reg_sel_e        sel,
  input  logic [NSRC-1:0] class_q,
  input  logic [NSRC-1:0] live_q,
  input  logic [NSRC-1:0] blocked_q,
  output logic [NSRC-1:0] rdata
);
  logic [NSRC-1:0] mux_v, rdata_q;

  always_comb begin
    case (sel)
      SEL_CLASS:   mux_v = class_q;
      SEL_BLOCKED: mux_v = blocked_q;
      SEL_LIVE:    mux_v = live_q;
      SEL_STATUS:  mux_v = live_q;
      default:     mux_v = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata_q <= '0;
    else        rdata_q <= rd_stb ? mux_v : '0;
  end

  assign rdata = rdata_q;

  // R10
  idle_rdata_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> rdata == '0);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NSRC-1:0]   src,
  input  logic              bus_valid,
  input  logic              bus_write,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NSRC-1:0]   bus_wdata,
  output logic [NSRC-1:0]   bus_rdata,
  output logic              irq
);
  reg_sel_e        sel;
  logic            wr_stb, rd_stb;
  logic [NSRC-1:0] chg, lvl, class_q, live_q, blocked_q;
  logic            irq_q;

  assign sel    = decode_offset(bus_addr);
  assign wr_stb = bus_valid && bus_write;
  assign rd_stb = bus_valid && !bus_write;

  irq_agg_srcdet #(.NSRC(NSRC)) u_srcdet (
    .clk(clk), .rst_n(rst_n), .src(src), .chg(chg), .lvl(lvl)
  );

  irq_agg_regfile #(.NSRC(NSRC)) u_regfile (
    .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .sel(sel), .wdata(bus_wdata),
    .chg(chg), .lvl(lvl), .class_q(class_q), .live_q(live_q), .blocked_q(blocked_q)
  );

  irq_agg_rdport #(.NSRC(NSRC)) u_rdport (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .sel(sel), .class_q(class_q),
    .live_q(live_q), .blocked_q(blocked_q), .rdata(bus_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |live_q;
  end

  assign irq = irq_q;

  // R5
  irq_follows_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq == $past(|live_q));
endmodule

// File: tb/irq_aggregator_bench.sv
module irq_aggregator_bench;
  localparam int unsigned NSRC = 32;
  localparam logic [1:0] K_SRC = 2'd0, K_WR = 2'd1, K_RD = 2'd2, K_IRQ = 2'd3;
  localparam int NV = 38;
  // {kind, offset, data-or-expected, requirement number}
  localparam logic [45:0] TBL [NV] = '{
    {K_RD,  8'h80, 32'h0000_0000, 4'd1},  // R1
    {K_RD,  8'h78, 32'h0000_0000, 4'd1},  // R1
    {K_RD,  8'h6C, 32'h0000_0000, 4'd1},  // R1
    {K_IRQ, 8'h00, 32'h0000_0000, 4'd1},  // R1
    {K_SRC, 8'h00, 32'h0000_0005, 4'd2},  // R2 bits 0,2 rise
    {K_RD,  8'h80, 32'h0000_0005, 4'd2},  // R2
    {K_RD,  8'h78, 32'h0000_0000, 4'd2},  // R2
    {K_RD,  8'h9C, 32'h0000_0005, 4'd6},  // R6 status alias
    {K_IRQ, 8'h00, 32'h0000_0001, 4'd5},  // R5
    {K_SRC, 8'h00, 32'h0000_0004, 4'd3},  // R3 bit 0 falls
    {K_RD,  8'h80, 32'h0000_0004, 4'd3},  // R3
    {K_RD,  8'h78, 32'h0000_0001, 4'd3},  // R3
    {K_WR,  8'h78, 32'h0000_0004, 4'd4},  // R4 block bit 2
    {K_RD,  8'h80, 32'h0000_0000, 4'd4},  // R4
    {K_RD,  8'h78, 32'h0000_0004, 4'd6},  // R6
    {K_IRQ, 8'h00, 32'h0000_0000, 4'd11}, // R11 source 2 still high
    {K_WR,  8'h80, 32'h0000_00F0, 4'd6},  // R6
    {K_RD,  8'h80, 32'h0000_00F0, 4'd6},  // R6
    {K_IRQ, 8'h00, 32'h0000_0001, 4'd5},  // R5
    {K_WR,  8'h80, 32'h0000_000F, 4'd4},  // R4 bit 2 masked
    {K_RD,  8'h80, 32'h0000_000B, 4'd4},  // R4
    {K_WR,  8'h6C, 32'hA5A5_5A5A, 4'd6},  // R6
    {K_RD,  8'h6C, 32'hA5A5_5A5A, 4'd6},  // R6
    {K_RD,  8'h80, 32'h0000_000B, 4'd8},  // R8
    {K_IRQ, 8'h00, 32'h0000_0001, 4'd8},  // R8
    {K_WR,  8'h80, 32'h0000_0000, 4'd5},  // R5
    {K_IRQ, 8'h00, 32'h0000_0000, 4'd5},  // R5
    {K_WR,  8'h6C, 32'hFFFF_FFFF, 4'd8},  // R8
    {K_IRQ, 8'h00, 32'h0000_0000, 4'd8},  // R8
    {K_RD,  8'h80, 32'h0000_0000, 4'd8},  // R8
    {K_WR,  8'h70, 32'hFFFF_FFFF, 4'd7},  // R7 unmapped write
    {K_RD,  8'h70, 32'h0000_0000, 4'd7},  // R7
    {K_RD,  8'h80, 32'h0000_0000, 4'd7},  // R7
    {K_RD,  8'h78, 32'h0000_0004, 4'd7},  // R7
    {K_WR,  8'h9C, 32'hFFFF_FFFF, 4'd7},  // R7 status write
    {K_RD,  8'h9C, 32'h0000_0000, 4'd7},  // R7
    {K_RD,  8'hFC, 32'h0000_0000, 4'd7},  // R7
    {K_RD,  8'h6C, 32'hFFFF_FFFF, 4'd7}   // R7
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [NSRC-1:0] src = '0;
  logic            bus_valid = 1'b0;
  logic            bus_write = 1'b0;
  logic [7:0]      bus_addr = '0;
  logic [NSRC-1:0] bus_wdata = '0;
  logic [NSRC-1:0] bus_rdata;
  logic            irq;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #2.5 clk = ~clk;

  irq_aggregator #(.NSRC(NSRC)) u_irq_aggregator (
    .clk(clk), .rst_n(rst_n), .src(src), .bus_valid(bus_valid), .bus_write(bus_write),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [NSRC-1:0] act, input logic [NSRC-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle();
    bus_valid = 1'b0; bus_write = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic bus_op(input logic wr, input logic [7:0] a, input logic [NSRC-1:0] d);
    bus_valid = 1'b1; bus_write = wr; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [NSRC-1:0] exp);
    bus_op(1'b0, a, '0); step(); idle();
    check(req, bus_rdata, exp);
  endtask

  initial begin
    @(negedge clk); @(negedge clk);
    check("R1 rdata", bus_rdata, '0);
    check("R1 irq", {31'b0, irq}, '0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [1:0] k;
      logic [7:0] a;
      logic [31:0] d;
      string tag;
      k = TBL[i][45:44]; a = TBL[i][43:36]; d = TBL[i][35:4];
      tag = $sformatf("R%0d vec %0d", TBL[i][3:0], i);
      case (k)
        K_SRC: begin src = d; step(); end
        K_WR:  begin bus_op(1'b1, a, d); step(); idle(); end
        K_RD:  rd_check(tag, a, d);
        default: begin idle(); step(); check(tag, {31'b0, irq}, {31'b0, d[0]}); end
      endcase
    end

    // R9: source change beats same-cycle write (src currently 0x4)
    src = 32'h0000_0204; step();
    rd_check("R9 live after rise", 8'h80, 32'h0000_0200);
    bus_op(1'b1, 8'h80, 32'h0000_0200); src = 32'h0000_0004; step(); idle();
    rd_check("R9 live write vs fall", 8'h80, 32'h0000_0000);
    rd_check("R9 blocked write vs fall", 8'h78, 32'h0000_0204);
    bus_op(1'b1, 8'h78, 32'hFFFF_FFFF); src = 32'h0000_0006; step(); idle();
    rd_check("R9 blocked write vs rise", 8'h78, 32'hFFFF_FFFD);
    rd_check("R9 live write vs rise", 8'h80, 32'h0000_0002);
    step();
    check("R5 irq after R9", {31'b0, irq}, 32'h1);

    // R10: one-cycle read latency, zero when idle
    check("R10 before read", bus_rdata, '0);
    bus_op(1'b0, 8'h6C, '0); step(); idle();
    check("R10 read data", bus_rdata, 32'hFFFF_FFFF);
    step();
    check("R10 idle zero", bus_rdata, '0);

    // R1: reset mid-run
    src = '0; step();
    rst_n = 1'b0; step(); rst_n = 1'b1; step();
    check("R1 irq after reset", {31'b0, irq}, '0);
    rd_check("R1 class after reset", 8'h6C, '0);
    rd_check("R1 live after reset", 8'h80, '0);
    rd_check("R1 blocked after reset", 8'h78, '0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule